// File: doc/BRIEF.md
# USB Host OUT Transaction Retry Controller

This block runs one host-side OUT transaction at a time toward a target endpoint and decides what happens once the handshake comes back. Software presents a 7-bit target address, an endpoint-control byte, a descriptor byte count and a token (PID plus endpoint number), then pulses a token-write strobe. The block captures those values and asks an abstracted packet engine to send the token and data phases. The engine answers with a completion strobe and the handshake it saw. A NAK is retried automatically with no limit unless the retry-disable bit is set. When the transaction ends, a status code is written into the descriptor PID field, and in the following cycle a transfer-done pulse marks the descriptor as returned.

A STALL sets a sticky stall flag that blocks the next transaction until software clears it. A separate watcher raises a detach flag when SE0 stays on the lines for longer than a parameterised number of clock cycles. Serialization, CRC, bit stuffing and the PHY are not part of the block. They sit behind the request/completion interface.

Top module: `usbHostRetry`

## Requirements
- R1: After reset, busy, pktReq, xferDone, stallFlag and detachFlag are 0 and bdPid is 0h.
- R2: A tokStart sampled while idle and not stalled makes busy and pktReq high in the next cycle, with pktReq lasting one cycle. pktAddr, pktEp, pktPid, pktLen and pktLowSpeed hold the values captured at that token write, and later input changes have no effect on them until the transaction ends.
- R3: pktLen equals the descriptor count when it is 64 or less, and is 64 otherwise.
- R4: pktLowSpeed follows bit 7 of the endpoint-control byte. Bit 6 of that byte is retry-disable.
- R5: When retry-disable is 0 and the handshake is NAK (PID Ah), pktReq rises again in the cycle after pktDone, with no xferDone, for any number of NAKs.
- R6: The final status written to bdPid is 2h for ACK, Ah for NAK (only when retry-disable is 1) and Eh for STALL. It is Fh when pktHsValid is low or the handshake PID is any other value, and in that case the transaction ends whatever retry-disable says.
- R7: A STALL sets stallFlag, which stays set until stallClr is sampled. A token written while stallFlag is set raises busy but issues no pktReq until the cycle after the first clock edge that sees stallFlag cleared.
- R8: xferDone is a single-cycle pulse in the cycle after the final pktDone. bdPid already holds the new status in that cycle, and busy falls in the cycle after it.
- R9: A tokStart while busy is ignored: it issues no extra request and busy is not extended.
- R10: detachFlag sets on the clock edge that samples lineSe0 high for the (DETACH_CYC+1)-th consecutive time. Any low sample restarts the count, and detachClr clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| tgtAddr | input | 7 | Target device address |
| epCtrl | input | 8 | Endpoint control byte (bit 7 low speed, bit 6 retry-disable) |
| bdLen | input | 10 | Descriptor byte count |
| tokPid | input | 4 | Token PID |
| tokEp | input | 4 | Token endpoint number |
| tokStart | input | 1 | Token write strobe |
| stallClr | input | 1 | Clears stallFlag |
| detachClr | input | 1 | Clears detachFlag |
| lineSe0 | input | 1 | Lines are in SE0 |
| pktDone | input | 1 | Packet engine finished an attempt |
| pktHsValid | input | 1 | A handshake was received |
| pktHsPid | input | 4 | Received handshake PID |
| pktReq | output | 1 | Start one token+data attempt |
| pktAddr | output | 7 | Captured target address |
| pktEp | output | 4 | Captured endpoint |
| pktPid | output | 4 | Captured token PID |
| pktLen | output | 7 | Data bytes for this packet |
| pktLowSpeed | output | 1 | Target is low speed |
| busy | output | 1 | Transaction in progress |
| xferDone | output | 1 | Descriptor returned, transaction over |
| bdPid | output | 4 | Status written to descriptor PID field |
| stallFlag | output | 1 | Target stalled |
| detachFlag | output | 1 | SE0 held past the detach limit |

## Verification
The hardest case to reach from the ports is a token that is parked behind a stall. It needs a STALL-ended transaction, a new token write while the flag is still set, a stretch of cycles with busy high and no request, and then a clear whose effect on pktReq appears exactly two edges later. The bench drives the engine side itself: it returns a STALL, writes the next token, watches pktReq stay low for several cycles, pulses stallClr and checks the cycle in which the request appears. The detach limit is tested on both sides of the boundary at the default count, including an interrupted run that has to restart the count.

// File: rtl/usbRetryPkg.sv
package usbRetryPkg;
  localparam logic [3:0] PID_ACK   = 4'h2;
  localparam logic [3:0] PID_NAK   = 4'hA;
  localparam logic [3:0] PID_STALL = 4'hE;
  localparam logic [3:0] PID_ERR   = 4'hF;

  typedef enum logic [1:0] {HS_ACK, HS_NAK, HS_STALL, HS_ERR} hsKind_t;

  typedef enum logic [2:0] {ST_IDLE, ST_HOLD, ST_ISSUE, ST_WAIT, ST_DONE} xactState_t;

  typedef struct packed {
    logic capture;
    logic writeResult;
  } ctrlStrobe_t;
endpackage

// File: rtl/usbRetryDatapath.sv
module usbRetryDatapath
  import usbRetryPkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int EP_W     = 4,
  parameter int BD_LEN_W = 10,
  parameter int MAX_PKT  = 64,
  parameter int LEN_W    = $clog2(MAX_PKT + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic [ADDR_W-1:0]   tgtAddr,
  input  logic [7:0]          epCtrl,
  input  logic [BD_LEN_W-1:0] bdLen,
  input  logic [3:0]          tokPid,
  input  logic [EP_W-1:0]     tokEp,
  input  logic                pktHsValid,
  input  logic [3:0]          pktHsPid,
  input  logic                stallClr,
  output logic [ADDR_W-1:0]   pktAddr,
  output logic [EP_W-1:0]     pktEp,
  output logic [3:0]          pktPid,
  output logic [LEN_W-1:0]    pktLen,
  output logic                pktLowSpeed,
  output logic                retryDis,
  output hsKind_t             hsKind,
  output logic [3:0]          bdPid,
  output logic                stallFlag
);
  logic [LEN_W-1:0] lenClip;
  logic [3:0]       statusCode;

  always_comb begin
    if (bdLen > BD_LEN_W'(MAX_PKT)) lenClip = LEN_W'(MAX_PKT);
    else                            lenClip = bdLen[LEN_W-1:0];
  end

  always_comb begin
    if (!pktHsValid) hsKind = HS_ERR;
    else begin
      case (pktHsPid)
        PID_ACK:   hsKind = HS_ACK;
        PID_NAK:   hsKind = HS_NAK;
        PID_STALL: hsKind = HS_STALL;
        default:   hsKind = HS_ERR;
      endcase
    end
  end

  always_comb begin
    case (hsKind)
      HS_ACK:   statusCode = PID_ACK;
      HS_NAK:   statusCode = PID_NAK;
      HS_STALL: statusCode = PID_STALL;
      default:  statusCode = PID_ERR;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktAddr     <= '0;
      pktEp       <= '0;
      pktPid      <= '0;
      pktLen      <= '0;
      pktLowSpeed <= 1'b0;
      retryDis    <= 1'b0;
    end else if (strb.capture) begin
      pktAddr     <= tgtAddr;
      pktEp       <= tokEp;
      pktPid      <= tokPid;
      pktLen      <= lenClip;
      pktLowSpeed <= epCtrl[7];
      retryDis    <= epCtrl[6];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bdPid     <= '0;
      stallFlag <= 1'b0;
    end else begin
      if (strb.writeResult) bdPid <= statusCode;
      if (strb.writeResult && hsKind == HS_STALL) stallFlag <= 1'b1;
      else if (stallClr)                          stallFlag <= 1'b0;
    end
  end

  a_r3_len_cap: assert property (@(posedge clk) disable iff (!rstN)
    pktLen <= LEN_W'(MAX_PKT));

  a_r7_stall_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (stallFlag && !stallClr) |=> stallFlag);
endmodule

// File: rtl/usbRetryControl.sv
module usbRetryControl
  import usbRetryPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tokStart,
  input  logic        pktDone,
  input  hsKind_t     hsKind,
  input  logic        retryDis,
  input  logic        stallFlag,
  output ctrlStrobe_t strb,
  output logic        pktReq,
  output logic        busy,
  output logic        xferDone
);
  xactState_t state, nextState;

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      ST_IDLE: if (tokStart) begin
        strb.capture = 1'b1;
        nextState    = stallFlag ? ST_HOLD : ST_ISSUE;
      end
      ST_HOLD:  if (!stallFlag) nextState = ST_ISSUE;
      ST_ISSUE: nextState = ST_WAIT;
      ST_WAIT: if (pktDone) begin
        if (hsKind == HS_NAK && !retryDis) nextState = ST_ISSUE;
        else begin
          strb.writeResult = 1'b1;
          nextState        = ST_DONE;
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign pktReq   = (state == ST_ISSUE);
  assign busy     = (state != ST_IDLE);
  assign xferDone = (state == ST_DONE);

  a_r5_nak_reissue: assert property (@(posedge clk) disable iff (!rstN)
    (pktDone && !pktReq && busy && hsKind == HS_NAK && !retryDis) |=> (pktReq && !xferDone));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> (!xferDone && !busy));
endmodule

// File: rtl/usbSe0Detach.sv
module usbSe0Detach #(
  parameter int DETACH_CYC = 625,
  parameter int CNT_W      = $clog2(DETACH_CYC + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineSe0,
  input  logic detachClr,
  output logic detachFlag
);
  logic [CNT_W-1:0] se0Cnt;
  logic             limitHit;

  assign limitHit = lineSe0 && (se0Cnt == CNT_W'(DETACH_CYC));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              se0Cnt <= '0;
    else if (!lineSe0)                      se0Cnt <= '0;
    else if (se0Cnt != CNT_W'(DETACH_CYC))  se0Cnt <= se0Cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          detachFlag <= 1'b0;
    else if (detachClr) detachFlag <= 1'b0;
    else if (limitHit)  detachFlag <= 1'b1;
  end

  a_r10_needs_se0: assert property (@(posedge clk) disable iff (!rstN)
    $rose(detachFlag) |-> $past(lineSe0));
endmodule

// File: rtl/usbHostRetry.sv
module usbHostRetry
  import usbRetryPkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int EP_W       = 4,
  parameter int BD_LEN_W   = 10,
  parameter int MAX_PKT    = 64,
  parameter int DETACH_CYC = 625,
  parameter int LEN_W      = $clog2(MAX_PKT + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   tgtAddr,
  input  logic [7:0]          epCtrl,
  input  logic [BD_LEN_W-1:0] bdLen,
  input  logic [3:0]          tokPid,
  input  logic [EP_W-1:0]     tokEp,
  input  logic                tokStart,
  input  logic                stallClr,
  input  logic                detachClr,
  input  logic                lineSe0,
  input  logic                pktDone,
  input  logic                pktHsValid,
  input  logic [3:0]          pktHsPid,
  output logic                pktReq,
  output logic [ADDR_W-1:0]   pktAddr,
  output logic [EP_W-1:0]     pktEp,
  output logic [3:0]          pktPid,
  output logic [LEN_W-1:0]    pktLen,
  output logic                pktLowSpeed,
  output logic                busy,
  output logic                xferDone,
  output logic [3:0]          bdPid,
  output logic                stallFlag,
  output logic                detachFlag
);
  ctrlStrobe_t strb;
  hsKind_t     hsKind;
  logic        retryDis;

  usbRetryControl uCtrl (
    .clk, .rstN, .tokStart, .pktDone, .hsKind, .retryDis, .stallFlag,
    .strb, .pktReq, .busy, .xferDone
  );

  usbRetryDatapath #(
    .ADDR_W(ADDR_W), .EP_W(EP_W), .BD_LEN_W(BD_LEN_W), .MAX_PKT(MAX_PKT), .LEN_W(LEN_W)
  ) uData (
    .clk, .rstN, .strb, .tgtAddr, .epCtrl, .bdLen, .tokPid, .tokEp,
    .pktHsValid, .pktHsPid, .stallClr,
    .pktAddr, .pktEp, .pktPid, .pktLen, .pktLowSpeed, .retryDis, .hsKind,
    .bdPid, .stallFlag
  );

  usbSe0Detach #(.DETACH_CYC(DETACH_CYC)) uDetach (
    .clk, .rstN, .lineSe0, .detachClr, .detachFlag
  );

  a_r7_no_req_stalled: assert property (@(posedge clk) disable iff (!rstN)
    stallFlag |-> !pktReq);

  a_r2_fields_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(pktAddr) && $stable(pktLen) && $stable(pktEp)));
endmodule

// File: tb/tb_usbHostRetry.sv
module tb_usbHostRetry;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] tgtAddr = '0;
  logic [7:0] epCtrl = '0;
  logic [9:0] bdLen = '0;
  logic [3:0] tokPid = '0;
  logic [3:0] tokEp = '0;
  logic tokStart = 0, stallClr = 0, detachClr = 0, lineSe0 = 0;
  logic pktDone = 0, pktHsValid = 0;
  logic [3:0] pktHsPid = '0;
  logic pktReq, pktLowSpeed, busy, xferDone, stallFlag, detachFlag;
  logic [6:0] pktAddr;
  logic [3:0] pktEp, pktPid, bdPid;
  logic [6:0] pktLen;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  usbHostRetry dut (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // token write from idle; leaves the controller waiting for the engine
  task automatic startXact();
    tokStart = 1;
    tick();
    tokStart = 0;
    chk("R2 pktReq", pktReq, 1);
    chk("R2 busy", busy, 1);
    tick();
    chk("R2 pktReq one cycle", pktReq, 0);
  endtask

  task automatic respond(input logic v, input logic [3:0] pid);
    pktDone = 1; pktHsValid = v; pktHsPid = pid;
    tick();
    pktDone = 0; pktHsValid = 0;
  endtask

  task automatic finishCheck(input logic [3:0] code, input string req);
    chk({req, " xferDone"}, xferDone, 1);
    chk({req, " bdPid"}, bdPid, code);
    tick();
    chk("R8 busy falls", busy, 0);
    chk("R8 done pulse", xferDone, 0);
  endtask

  task automatic testReset();
    chk("R1 busy", busy, 0);
    chk("R1 pktReq", pktReq, 0);
    chk("R1 xferDone", xferDone, 0);
    chk("R1 bdPid", bdPid, 0);
    chk("R1 stallFlag", stallFlag, 0);
    chk("R1 detachFlag", detachFlag, 0);
  endtask

  task automatic testBasic();
    tgtAddr = 7'h55; tokEp = 4'h3; tokPid = 4'h1; epCtrl = 8'h9D; bdLen = 10'd40;
    tokStart = 1;
    tick();
    tokStart = 0;
    chk("R2 pktReq", pktReq, 1);
    chk("R2 pktAddr", pktAddr, 'h55);
    chk("R2 pktEp", pktEp, 3);
    chk("R2 pktPid", pktPid, 1);
    chk("R3 pktLen", pktLen, 40);
    chk("R4 lowSpeed", pktLowSpeed, 1);
    tgtAddr = 7'h11; bdLen = 10'd5; epCtrl = 8'h1D;
    tick();
    chk("R2 addr held", pktAddr, 'h55);
    chk("R2 len held", pktLen, 40);
    tokStart = 1;                       // R9: write while busy
    respond(1, 4'h2);
    tokStart = 0;
    chk("R8 busy in done", busy, 1);
    finishCheck(4'h2, "R6 ack");
    chk("R9 no extra req", pktReq, 0);
    tick();
    chk("R9 stays idle", busy, 0);
    chk("R4 lowSpeed still captured", pktLowSpeed, 1);
  endtask

  task automatic testLen();
    int lens[3] = '{100, 64, 0};
    int exps[3] = '{64, 64, 0};
    epCtrl = 8'h1D;
    for (int i = 0; i < 3; i++) begin
      bdLen = 10'(lens[i]);
      startXact();
      chk("R3 clipped len", pktLen, exps[i]);
      chk("R4 full speed", pktLowSpeed, 0);
      respond(1, 4'h2);
      finishCheck(4'h2, "R6 ack");
    end
  endtask

  task automatic testNakRetry();
    epCtrl = 8'h1D; bdLen = 10'd8;
    startXact();
    for (int n = 0; n < 4; n++) begin
      respond(1, 4'hA);
      chk("R5 reissue", pktReq, 1);
      chk("R5 no done", xferDone, 0);
      tick();
    end
    respond(1, 4'h2);
    finishCheck(4'h2, "R5 final ack");
  endtask

  task automatic testRetryDis();
    epCtrl = 8'h5D;
    startXact();
    respond(1, 4'hA);
    finishCheck(4'hA, "R6 nak kept");
    startXact();
    respond(0, 4'h2);
    finishCheck(4'hF, "R6 no handshake");
    startXact();
    respond(1, 4'h3);
    finishCheck(4'hF, "R6 bad pid");
    epCtrl = 8'h1D;
    startXact();
    respond(0, 4'h0);
    finishCheck(4'hF, "R6 error without retryDis");
  endtask

  task automatic testStall();
    epCtrl = 8'h1D;
    startXact();
    respond(1, 4'hE);
    chk("R7 stallFlag", stallFlag, 1);
    finishCheck(4'hE, "R6 stall");
    tokStart = 1;
    tick();
    tokStart = 0;
    chk("R7 busy parked", busy, 1);
    for (int k = 0; k < 3; k++) begin
      chk("R7 blocked", pktReq, 0);
      tick();
    end
    chk("R7 flag held", stallFlag, 1);
    stallClr = 1;
    tick();
    stallClr = 0;
    chk("R7 flag cleared", stallFlag, 0);
    chk("R7 not yet", pktReq, 0);
    tick();
    chk("R7 released", pktReq, 1);
    tick();
    respond(1, 4'h2);
    finishCheck(4'h2, "R7 after clear");
  endtask

  task automatic testDetach();
    lineSe0 = 1;
    for (int i = 0; i < 625; i++) tick();
    chk("R10 not yet at limit", detachFlag, 0);
    tick();
    chk("R10 past limit", detachFlag, 1);
    lineSe0 = 0;
    detachClr = 1;
    tick();
    detachClr = 0;
    chk("R10 cleared", detachFlag, 0);
    lineSe0 = 1;
    for (int i = 0; i < 624; i++) tick();
    lineSe0 = 0;
    tick();
    lineSe0 = 1;
    for (int i = 0; i < 625; i++) tick();
    chk("R10 count restarted", detachFlag, 0);
    tick();
    chk("R10 set after restart", detachFlag, 1);
    lineSe0 = 0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    tick();
    tick();
    testReset();
    rstN = 1;
    tick();
    testReset();
    testBasic();
    testLen();
    testNakRetry();
    testRetryDis();
    testStall();
    testDetach();
    report();
  end
endmodule